// File: doc/BRIEF.md
# Timer Interrupt Reinjection Tracker

This block sits between the expiry strobe of a periodic timer and the request line into an interrupt controller. It keeps count of timer ticks that have not yet been serviced and decides when a tick turns into an interrupt pulse. A new pulse goes out only after the previous one has been acknowledged. Ticks that arrive while the controller is still busy are either kept and replayed one per acknowledge (catch-up mode) or dropped, as selected by a reinject enable input.

Every interrupt is a single-cycle high pulse on the output line. Internally the block holds a saturating count of outstanding ticks, a flag that records whether the last pulse has been acknowledged, and a one-cycle delivery attempt. An acknowledge that arrives with nothing outstanding is harmless. Unmasking the line at the controller or reprogramming the timer returns the block to its idle state.

Top module: `tick_reinject_tracker`

## Requirements
- R1: After reset the output is low, the outstanding count is 0 and the acknowledged flag is set, so the first tick produces a pulse.
- R2: A tick while reinject is 1, or while the count is 0, raises the count by one and schedules a delivery attempt. With the flag set, the output is high during the second cycle after the clock edge that sampled the tick.
- R3: A tick while reinject is 0 and the count is above 0 leaves the count unchanged and schedules nothing.
- R4: The count saturates at 2^CNT_W-1. Further counted ticks still schedule an attempt but do not wrap the count.
- R5: An acknowledge lowers the count by one. An acknowledge at count 0 leaves it at 0 and produces no pulse.
- R6: A tick and an acknowledge sampled in the same cycle leave the count unchanged, set the flag and schedule an attempt.
- R7: A delivery attempt yields a pulse only while the flag is set and clears the flag. An attempt made while the flag is clear is discarded. Every pulse lasts exactly one cycle.
- R8: Every acknowledge sets the flag. If the count is still above 0 after the decrement, an attempt is scheduled, giving a pulse two cycles after the acknowledge edge.
- R9: An unmask or reprogram strobe clears the count to 0, sets the flag and cancels any pending attempt. It takes priority over a tick or acknowledge in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| expire_i | input | 1 | Timer expiry strobe, one cycle per tick |
| ack_i | input | 1 | Interrupt acknowledge strobe from the controller |
| unmask_i | input | 1 | Line unmask strobe; clears the tracker |
| reprog_i | input | 1 | Timer reprogram strobe; clears the tracker |
| reinject_en_i | input | 1 | 1 = replay missed ticks, 0 = drop them |
| irq_o | output | 1 | Interrupt request, a one-cycle pulse per delivery |

## Verification
A wrong count stays hidden until acknowledges drain it. It shows as one pulse too many or too few in the catch-up train after a burst of ticks, so the bench builds bursts longer than the counter range and then drains them acknowledge by acknowledge. A stuck or wrongly cleared acknowledged flag shows within two cycles of the next tick or acknowledge, as a pulse that is missing or extra. A reference model compares the line on every cycle, so any of these errors is reported at the cycle where the pulse should or should not have appeared.

// File: rtl/tick_reinj_pkg.sv
package tick_reinj_pkg;

   // Decoded per-cycle event; a clear outranks everything else
   typedef enum logic [2:0] {
      EV_IDLE  = 3'd0,
      EV_TICK  = 3'd1,
      EV_ACK   = 3'd2,
      EV_BOTH  = 3'd3,
      EV_CLEAR = 3'd4
   } tr_evt_e;

   localparam int unsigned TR_CNT_W_MIN = 1;
   localparam int unsigned TR_CNT_W_MAX = 16;

endpackage

// File: rtl/tr_event_decode.sv
module tr_event_decode
   import tick_reinj_pkg::*;
(
   input  logic    expire_i,
   input  logic    ack_i,
   input  logic    unmask_i,
   input  logic    reprog_i,
   output tr_evt_e evt_o,
   output logic    clear_o,
   output logic    ack_eff_o
);

   always_comb begin
      clear_o = unmask_i | reprog_i;
      if (clear_o)                 evt_o = EV_CLEAR;
      else if (expire_i && ack_i)  evt_o = EV_BOTH;
      else if (expire_i)           evt_o = EV_TICK;
      else if (ack_i)              evt_o = EV_ACK;
      else                         evt_o = EV_IDLE;
      ack_eff_o = ack_i & ~clear_o;
   end

endmodule

// File: rtl/tr_pend_counter.sv
module tr_pend_counter
   import tick_reinj_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tr_evt_e          evt_i,
   input  logic             reinject_en_i,
   output logic [CNT_W-1:0] pend_o,
   output logic             sched_req_o
);

   localparam logic [CNT_W-1:0] PEND_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] PEND_ZERO = '0;
   localparam logic [CNT_W-1:0] PEND_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] pend_q, pend_d;
   logic             counts_tick;
   logic             is_zero, is_full;

   assign is_zero     = (pend_q == PEND_ZERO);
   assign is_full     = (pend_q == PEND_MAX);
   assign counts_tick = reinject_en_i | is_zero;

   always_comb begin
      pend_d      = pend_q;
      sched_req_o = 1'b0;
      unique case (evt_i)
         EV_TICK: begin
            if (counts_tick) begin
               pend_d      = is_full ? pend_q : pend_q + PEND_ONE;
               sched_req_o = 1'b1;
            end
         end
         EV_ACK: begin
            pend_d      = is_zero ? PEND_ZERO : pend_q - PEND_ONE;
            sched_req_o = (pend_d != PEND_ZERO);
         end
         EV_BOTH: begin
            sched_req_o = 1'b1;
         end
         EV_CLEAR: begin
            pend_d = PEND_ZERO;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= PEND_ZERO;
      else        pend_q <= pend_d;
   end

   assign pend_o = pend_q;

   // R2: a counted tick below the ceiling adds exactly one
   p_tick_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == EV_TICK && counts_tick && !is_full) |=> (pend_q == $past(pend_q) + PEND_ONE));
   // R3: dropped tick leaves the count alone
   p_tick_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == EV_TICK && !reinject_en_i && !is_zero) |=> $stable(pend_q));
   // R4: no wrap at the ceiling
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == EV_TICK && is_full) |=> (pend_q == PEND_MAX));
   // R5: spurious acknowledge never underflows
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == EV_ACK && is_zero) |=> (pend_q == PEND_ZERO));
   // R6: simultaneous tick and acknowledge cancel
   p_both_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == EV_BOTH) |=> $stable(pend_q));
   // R9: clear empties the count
   p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == EV_CLEAR) |=> (pend_q == PEND_ZERO));

endmodule

// File: rtl/tr_deliver_gate.sv
module tr_deliver_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic sched_req_i,
   input  logic ack_i,
   input  logic clear_i,
   output logic irq_o
);

   logic sched_q, acked_q, irq_q;
   logic deliver;
   logic sched_d, acked_d;

   // An attempt waits out a pulse still on the line so pulses never merge
   assign deliver = sched_q & acked_q & ~irq_q & ~clear_i;

   always_comb begin
      if (clear_i) begin
         sched_d = 1'b0;
         acked_d = 1'b1;
      end else begin
         sched_d = sched_req_i | (sched_q & irq_q);
         if (ack_i)        acked_d = 1'b1;
         else if (deliver) acked_d = 1'b0;
         else              acked_d = acked_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sched_q <= 1'b0;
         acked_q <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         sched_q <= sched_d;
         acked_q <= acked_d;
         irq_q   <= deliver;
      end
   end

   assign irq_o = irq_q;

   // R7: an attempt with the flag clear yields no pulse
   p_gate_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sched_q && !acked_q) |=> !irq_o);
   // R7: pulses are a single cycle wide
   p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   // R8: every acknowledge leaves the flag set
   p_ack_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> acked_q);
   // R9: clear cancels and re-arms
   p_clear_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (acked_q && !sched_q && !irq_o));

endmodule

// File: rtl/tick_reinject_tracker.sv
module tick_reinject_tracker
   import tick_reinj_pkg::*;
#(
   parameter int unsigned CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic ack_i,
   input  logic unmask_i,
   input  logic reprog_i,
   input  logic reinject_en_i,
   output logic irq_o
);

   if (CNT_W < TR_CNT_W_MIN || CNT_W > TR_CNT_W_MAX) begin : g_bad_width
      $error("tick_reinject_tracker: CNT_W out of range");
   end

   tr_evt_e          evt;
   logic             clear;
   logic             ack_eff;
   logic             sched_req;
   logic [CNT_W-1:0] pend;

   tr_event_decode u_decode (
      .expire_i  (expire_i),
      .ack_i     (ack_i),
      .unmask_i  (unmask_i),
      .reprog_i  (reprog_i),
      .evt_o     (evt),
      .clear_o   (clear),
      .ack_eff_o (ack_eff)
   );

   tr_pend_counter #(.CNT_W(CNT_W)) u_count (
      .clk           (clk),
      .rst_n         (rst_n),
      .evt_i         (evt),
      .reinject_en_i (reinject_en_i),
      .pend_o        (pend),
      .sched_req_o   (sched_req)
   );

   tr_deliver_gate u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .sched_req_i (sched_req),
      .ack_i       (ack_eff),
      .clear_i     (clear),
      .irq_o       (irq_o)
   );

   // R1: the line is low during and right after reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> !irq_o);
   // R5: an acknowledge with nothing outstanding schedules nothing
   p_spurious_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == EV_ACK && pend == '0) |-> !sched_req);

endmodule

// File: tb/tick_reinject_tracker_tb.sv
`timescale 1ns/1ps
module tick_reinject_tracker_tb;

   localparam int CNT_W = 4;
   localparam int PMAX  = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic expire_i = 1'b0, ack_i = 1'b0, unmask_i = 1'b0, reprog_i = 1'b0;
   logic reinject_en_i = 1'b1;
   logic irq_o;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_pend = 0;
   bit m_ack  = 1'b1;
   bit m_att  = 1'b0;
   bit m_irq  = 1'b0;

   always #2 clk = ~clk;

   tick_reinject_tracker #(.CNT_W(CNT_W)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .expire_i      (expire_i),
      .ack_i         (ack_i),
      .unmask_i      (unmask_i),
      .reprog_i      (reprog_i),
      .reinject_en_i (reinject_en_i),
      .irq_o         (irq_o)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend = 0; m_ack = 1'b1; m_att = 1'b0; m_irq = 1'b0;
      end else if (unmask_i || reprog_i) begin
         m_pend = 0; m_ack = 1'b1; m_att = 1'b0; m_irq = 1'b0;
      end else begin
         bit fire, again;
         fire  = m_att && m_ack && !m_irq;
         again = 1'b0;
         if (expire_i && ack_i) begin
            again = 1'b1;
         end else if (expire_i) begin
            if (reinject_en_i || m_pend == 0) begin
               if (m_pend < PMAX) m_pend++;
               again = 1'b1;
            end
         end else if (ack_i) begin
            if (m_pend > 0) m_pend--;
            again = (m_pend > 0);
         end
         if (ack_i)     m_ack = 1'b1;
         else if (fire) m_ack = 1'b0;
         m_att = again || (m_att && m_irq);
         m_irq = fire;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (irq_o !== m_irq) begin
            errors++;
            $display("FAIL %s: irq_o actual=%0b expected=%0b at %0t", cur_req, irq_o, m_irq, $time);
         end
         if (irq_o === 1'b1) pulses++;
      end
   end

   task automatic check(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   // set strobes at a falling edge, hold one cycle, then idle
   task automatic ev(input bit t, input bit a, input bit u, input bit r, input int idle);
      expire_i = t; ack_i = a; unmask_i = u; reprog_i = r;
      @(negedge clk);
      expire_i = 1'b0; ack_i = 1'b0; unmask_i = 1'b0; reprog_i = 1'b0;
      repeat (idle) @(negedge clk);
   endtask

   function automatic int since(input int base);
      return pulses - base;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check("R1 irq low in reset", int'(irq_o), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      #1 check("R1 no pulse after reset", pulses, 0);

      // R2 / R7 / R8 / R5: catch-up with reinject on
      cur_req = "R2";
      base = pulses;
      ev(1, 0, 0, 0, 1);
      #1 check("R2 pulse two cycles after tick", int'(irq_o), 1);
      @(negedge clk);
      ev(1, 0, 0, 0, 5);
      ev(1, 0, 0, 0, 5);
      #1 check("R7 no pulse while unacknowledged", since(base), 1);
      cur_req = "R8";
      ev(0, 1, 0, 0, 5);
      ev(0, 1, 0, 0, 5);
      #1 check("R8 replay after each ack", since(base), 3);
      ev(0, 1, 0, 0, 5);
      cur_req = "R5";
      ev(0, 1, 0, 0, 5);
      #1 check("R5 drained and spurious ack quiet", since(base), 3);
      cur_req = "R2";
      ev(1, 0, 0, 0, 5);
      #1 check("R2 fresh tick after drain", since(base), 4);

      // R3: dropping mode
      cur_req = "R3";
      reinject_en_i = 1'b0;
      ev(0, 0, 0, 1, 4);
      base = pulses;
      ev(1, 0, 0, 0, 5);
      ev(1, 0, 0, 0, 3);
      ev(1, 0, 0, 0, 3);
      ev(1, 0, 0, 0, 3);
      ev(0, 1, 0, 0, 5);
      #1 check("R3 extra ticks dropped", since(base), 1);
      ev(0, 1, 0, 0, 5);
      ev(1, 0, 0, 0, 5);
      #1 check("R3 next tick delivers", since(base), 2);

      // R4: saturation
      cur_req = "R4";
      reinject_en_i = 1'b1;
      ev(0, 0, 1, 0, 4);
      base = pulses;
      for (int i = 0; i < PMAX + 5; i++) ev(1, 0, 0, 0, 3);
      for (int i = 0; i < PMAX + 5; i++) ev(0, 1, 0, 0, 4);
      #1 check("R4 count capped at max", since(base), PMAX);

      // R6: tick with ack in one cycle
      cur_req = "R6";
      ev(0, 0, 0, 1, 4);
      base = pulses;
      ev(1, 0, 0, 0, 5);
      ev(1, 0, 0, 0, 5);
      ev(1, 1, 0, 0, 5);
      #1 check("R6 combined event schedules", since(base), 2);
      ev(0, 1, 0, 0, 5);
      ev(0, 1, 0, 0, 5);
      #1 check("R6 count unchanged by combined event", since(base), 3);

      // R9: clear priority and cancellation
      cur_req = "R9";
      ev(0, 0, 1, 0, 4);
      base = pulses;
      ev(1, 0, 0, 0, 0);
      ev(0, 0, 1, 0, 5);
      #1 check("R9 clear cancels attempt", since(base), 0);
      ev(0, 1, 0, 0, 5);
      ev(1, 0, 1, 0, 5);
      ev(1, 1, 0, 1, 5);
      #1 check("R9 clear wins same cycle", since(base), 0);
      ev(1, 0, 0, 0, 5);
      #1 check("R9 armed after clear", since(base), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule